// File: doc/BRIEF.md
# Pre-execution thread trace cache

This block keeps a small table of pre-execution threads. Each thread is a short trace of instructions taken from a backward slice. It is keyed by the address of the instruction that triggers it. The trigger is not stored as part of the trace. Only the instructions that follow it are stored, and they are kept in a fixed order with no control flow. Instruction words are opaque payloads, so a branch is held and delivered like any other word.

The trace-building side writes a thread in two steps. It first sends a header carrying the trigger PC and the body length. It then sends the body words, one per cycle. The main thread presents the PC of every instruction it executes on the lookup port. When that PC matches a complete, valid entry, the block raises a one-cycle fork request. In the same cycle it begins streaming that entry's body to a fetch-injection interface with valid/ready handshaking, and it marks the final word with a last flag.

Only one thread streams at a time. A trigger match that arrives during a stream is dropped and counted in a saturating counter. A single invalidate input clears the whole table in one cycle.

Top module: `prex_trace_cache`

## Requirements
- R1: After reset, `out_valid`, `fork_req` and `drop_cnt` are 0, and every entry is invalid, so no lookup produces a fork.
- R2: A lookup with `lk_valid` high whose PC equals the trigger PC of a valid entry, made while no stream is active, produces the following effects one clock later. `fork_req` is high for exactly one cycle, and `out_valid` is high with the first body word.
- R3: The body is delivered in stored order, one word per cycle in which `out_valid` and `out_ready` are both high, for exactly the stored length. `out_last` is high on the final word only. After the final word is accepted, `out_valid` falls.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_insn` and `out_last` hold their values. This holds provided the streaming entry is not being reloaded.
- R5: A trigger match that arrives while a stream is active is dropped. It causes no fork, it leaves the current stream's words and order unchanged, and it adds 1 to `drop_cnt`.
- R6: `drop_cnt` saturates at 2^DROP_W-1 (255 by default) and never wraps.
- R7: Loading a header whose trigger PC matches a valid entry reuses that entry. The old body is replaced and the new length applies.
- R8: A new trigger PC takes a free entry while one exists, so loading up to 16 distinct threads evicts none. When all entries are valid, the victim is chosen round-robin. The pointer starts at entry 0 and advances by one for each replacement.
- R9: An entry cannot hit until all of its body words have been written. Its old contents stop hitting as soon as its header is accepted.
- R10: `inv_all` clears every valid bit in one cycle and abandons a partly written entry. A stream already in progress still runs to completion.
- R11: A thread of length 1 streams a single word with `out_last` high.
- R12: A lookup with `lk_valid` low, or with a PC that matches no valid entry, produces no fork and no stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clear all entries |
| ld_hdr | input | 1 | Header strobe for a thread load |
| ld_pc | input | PC_W | Trigger PC of the thread being loaded |
| ld_len | input | clog2(MAX_LEN+1) | Body length, 1 to MAX_LEN |
| ld_wr | input | 1 | Body word strobe |
| ld_word | input | INSN_W | Body word, written in trace order |
| lk_valid | input | 1 | Main-thread instruction executed |
| lk_pc | input | PC_W | PC of that instruction |
| fork_req | output | 1 | One-cycle fork request |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Injection side accepts word |
| out_insn | output | INSN_W | Stream word |
| out_last | output | 1 | Final word of the thread |
| drop_cnt | output | DROP_W | Saturating dropped-fork count |

## Verification
The assertions check the streaming handshake on every cycle. A fork always coincides with a valid word and never repeats on the next cycle. A stalled word holds, `out_last` is only seen with `out_valid`, and the drop counter only steps up by one and stays put once saturated. The bench's scenarios are needed to show the rest: which entry a PC hits, the word values and order, overwrite and round-robin replacement, the invisibility of a partly loaded entry, and the effect of invalidation on the table but not on a running stream.

// File: rtl/prex_pkg.sv
package prex_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_MAX_LEN = 32;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_INSN_W  = 32;
  localparam int unsigned DEF_DROP_W  = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_STREAM = 1'b1} stream_st_e;
endpackage

// File: rtl/prex_entry_store.sv
module prex_entry_store #(
  parameter int unsigned NUM     = prex_pkg::DEF_ENTRIES,
  parameter int unsigned MAX_LEN = prex_pkg::DEF_MAX_LEN,
  parameter int unsigned PC_W    = prex_pkg::DEF_PC_W,
  parameter int unsigned INSN_W  = prex_pkg::DEF_INSN_W,
  localparam int unsigned SLOT_W = $clog2(NUM),
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              ld_hdr,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_wr,
  input  logic [INSN_W-1:0] ld_word,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [LEN_W-1:0]  hit_len,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [INSN_W-1:0] rd_word
);
  logic [NUM-1:0]    valid_q, valid_d;
  logic [PC_W-1:0]   pc_q  [NUM];
  logic [LEN_W-1:0]  len_q [NUM];
  logic [INSN_W-1:0] mem_q [NUM][MAX_LEN];
  logic              filling_q, filling_d;
  logic [SLOT_W-1:0] fill_slot_q, fill_slot_d;
  logic [IDX_W-1:0]  fill_idx_q, fill_idx_d;
  logic [LEN_W-1:0]  fill_len_q, fill_len_d;
  logic [SLOT_W-1:0] rr_q, rr_d;

  logic [NUM-1:0]    lk_match, ld_match;
  logic [SLOT_W-1:0] victim;
  logic              use_rr;
  logic              hdr_en, word_en;

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (pc_q[g] == lk_pc);
    assign ld_match[g] = valid_q[g] && (pc_q[g] == ld_pc);
  end

  // Lookup: lowest matching entry
  always_comb begin
    hit_slot = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (lk_match[i]) hit_slot = SLOT_W'(i);
    end
  end
  assign hit     = lk_valid && (|lk_match);
  assign hit_len = len_q[hit_slot];
  assign rd_word = mem_q[rd_slot][rd_idx];

  // Load target: same trigger, else lowest free, else round-robin
  always_comb begin
    victim = rr_q;
    use_rr = 1'b1;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        victim = SLOT_W'(i);
        use_rr = 1'b0;
      end
    end
    for (int i = NUM - 1; i >= 0; i--) begin
      if (ld_match[i]) begin
        victim = SLOT_W'(i);
        use_rr = 1'b0;
      end
    end
  end

  assign hdr_en  = ld_hdr && !inv_all;
  assign word_en = ld_wr && filling_q && !ld_hdr && !inv_all;

  always_comb begin
    valid_d     = valid_q;
    filling_d   = filling_q;
    fill_slot_d = fill_slot_q;
    fill_idx_d  = fill_idx_q;
    fill_len_d  = fill_len_q;
    rr_d        = rr_q;
    if (inv_all) begin
      valid_d   = '0;
      filling_d = 1'b0;
    end else if (hdr_en) begin
      valid_d[victim] = 1'b0;
      filling_d       = 1'b1;
      fill_slot_d     = victim;
      fill_idx_d      = '0;
      fill_len_d      = ld_len;
      if (use_rr) rr_d = (rr_q == SLOT_W'(NUM - 1)) ? '0 : rr_q + SLOT_W'(1);
    end else if (word_en) begin
      fill_idx_d = fill_idx_q + IDX_W'(1);
      if (LEN_W'(fill_idx_q) + LEN_W'(1) == fill_len_q) begin
        valid_d[fill_slot_q] = 1'b1;
        filling_d            = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      filling_q   <= 1'b0;
      fill_slot_q <= '0;
      fill_idx_q  <= '0;
      fill_len_q  <= '0;
      rr_q        <= '0;
    end else begin
      valid_q     <= valid_d;
      filling_q   <= filling_d;
      fill_slot_q <= fill_slot_d;
      fill_idx_q  <= fill_idx_d;
      fill_len_q  <= fill_len_d;
      rr_q        <= rr_d;
    end
  end

  // Payload storage: no reset, guarded by valid bits
  always_ff @(posedge clk) begin
    if (hdr_en) begin
      pc_q[victim]  <= ld_pc;
      len_q[victim] <= ld_len;
    end
    if (word_en) mem_q[fill_slot_q][fill_idx_q] <= ld_word;
  end
endmodule

// File: rtl/prex_streamer.sv
module prex_streamer #(
  parameter int unsigned MAX_LEN = prex_pkg::DEF_MAX_LEN,
  parameter int unsigned SLOT_W  = 4,
  parameter int unsigned DROP_W  = prex_pkg::DEF_DROP_W,
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [SLOT_W-1:0] hit_slot,
  input  logic [LEN_W-1:0]  hit_len,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              fork_req,
  output logic              out_valid,
  output logic              out_last,
  output logic [DROP_W-1:0] drop_cnt
);
  import prex_pkg::*;
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  stream_st_e        st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              fork_q, fork_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              active;

  assign active    = (st_q == ST_STREAM);
  assign out_valid = active;
  assign out_last  = active && (LEN_W'(idx_q) + LEN_W'(1) == len_q);
  assign rd_slot   = slot_q;
  assign rd_idx    = idx_q;
  assign fork_req  = fork_q;
  assign drop_cnt  = drop_q;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    idx_d  = idx_q;
    len_d  = len_q;
    fork_d = 1'b0;
    drop_d = drop_q;
    if (active && out_ready) begin
      if (out_last) st_d = ST_IDLE;
      else          idx_d = idx_q + IDX_W'(1);
    end
    if (hit) begin
      if (!active) begin
        st_d   = ST_STREAM;
        slot_d = hit_slot;
        idx_d  = '0;
        len_d  = hit_len;
        fork_d = 1'b1;
      end else if (drop_q != DROP_MAX) begin
        drop_d = drop_q + DROP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      fork_q <= 1'b0;
      drop_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      fork_q <= fork_d;
      drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/prex_trace_cache.sv
module prex_trace_cache #(
  parameter int unsigned NUM     = prex_pkg::DEF_ENTRIES,
  parameter int unsigned MAX_LEN = prex_pkg::DEF_MAX_LEN,
  parameter int unsigned PC_W    = prex_pkg::DEF_PC_W,
  parameter int unsigned INSN_W  = prex_pkg::DEF_INSN_W,
  parameter int unsigned DROP_W  = prex_pkg::DEF_DROP_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inv_all,
  input  logic                         ld_hdr,
  input  logic [PC_W-1:0]              ld_pc,
  input  logic [$clog2(MAX_LEN+1)-1:0] ld_len,
  input  logic                         ld_wr,
  input  logic [INSN_W-1:0]            ld_word,
  input  logic                         lk_valid,
  input  logic [PC_W-1:0]              lk_pc,
  output logic                         fork_req,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [INSN_W-1:0]            out_insn,
  output logic                         out_last,
  output logic [DROP_W-1:0]            drop_cnt
);
  localparam int unsigned SLOT_W = $clog2(NUM);
  localparam int unsigned IDX_W  = $clog2(MAX_LEN);
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1);

  logic              hit;
  logic [SLOT_W-1:0] hit_slot, rd_slot;
  logic [LEN_W-1:0]  hit_len;
  logic [IDX_W-1:0]  rd_idx;

  prex_entry_store #(.NUM(NUM), .MAX_LEN(MAX_LEN), .PC_W(PC_W), .INSN_W(INSN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .ld_hdr(ld_hdr), .ld_pc(ld_pc), .ld_len(ld_len), .ld_wr(ld_wr), .ld_word(ld_word),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .hit(hit), .hit_slot(hit_slot), .hit_len(hit_len),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_word(out_insn)
  );

  prex_streamer #(.MAX_LEN(MAX_LEN), .SLOT_W(SLOT_W), .DROP_W(DROP_W)) u_stream (
    .clk(clk), .rst_n(rst_n),
    .hit(hit), .hit_slot(hit_slot), .hit_len(hit_len), .out_ready(out_ready),
    .rd_slot(rd_slot), .rd_idx(rd_idx),
    .fork_req(fork_req), .out_valid(out_valid), .out_last(out_last), .drop_cnt(drop_cnt)
  );
endmodule

// File: rtl/prex_trace_cache_chk.sv
module prex_trace_cache_chk #(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fork_req,
  input logic              out_valid,
  input logic              out_ready,
  input logic [INSN_W-1:0] out_insn,
  input logic              out_last,
  input logic [DROP_W-1:0] drop_cnt
);
  localparam logic [DROP_W-1:0] DMAX = {DROP_W{1'b1}};

  assert_fork_has_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fork_req |-> out_valid);
  assert_fork_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fork_req |=> !fork_req);
  assert_last_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) && $stable(out_last)));
  assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + DROP_W'(1)));
  assert_drop_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == DMAX) |=> (drop_cnt == DMAX));
endmodule

bind prex_trace_cache prex_trace_cache_chk #(.INSN_W(INSN_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fork_req(fork_req), .out_valid(out_valid),
  .out_ready(out_ready), .out_insn(out_insn), .out_last(out_last), .drop_cnt(drop_cnt)
);

// File: tb/prex_trace_cache_tb.sv
module prex_trace_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0, ld_hdr = 1'b0, ld_wr = 1'b0, lk_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] ld_pc = '0, ld_word = '0, lk_pc = '0;
  logic [5:0]  ld_len = '0;
  logic        fork_req, out_valid, out_last;
  logic [31:0] out_insn;
  logic [7:0]  drop_cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2ns clk = ~clk;

  prex_trace_cache u_dut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .ld_hdr(ld_hdr), .ld_pc(ld_pc), .ld_len(ld_len), .ld_wr(ld_wr), .ld_word(ld_word),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .fork_req(fork_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_last(out_last), .drop_cnt(drop_cnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] pc;
    logic        hit;
    logic [5:0]  len;
    logic [7:0]  salt;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{32'h0000_1000, 1'b1, 6'd5,  8'h11},
    '{32'h0000_3000, 1'b1, 6'd32, 8'h33},
    '{32'h0000_1004, 1'b0, 6'd0,  8'h00},
    '{32'h0000_2000, 1'b1, 6'd1,  8'h22},
    '{32'h0000_4000, 1'b1, 6'd3,  8'h44},
    '{32'h0000_0000, 1'b0, 6'd0,  8'h00}
  };

  function automatic logic [31:0] wfun(logic [31:0] pc, logic [7:0] salt, int i);
    return pc ^ {salt, 24'd0} ^ {16'(i), 16'(i * 3)};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hdr(logic [31:0] pc, int len);
    ld_hdr = 1'b1; ld_pc = pc; ld_len = 6'(len);
    step();
    ld_hdr = 1'b0;
  endtask

  task automatic words(logic [31:0] pc, logic [7:0] salt, int first, int cnt);
    for (int i = first; i < first + cnt; i++) begin
      ld_wr = 1'b1; ld_word = wfun(pc, salt, i);
      step();
    end
    ld_wr = 1'b0;
  endtask

  task automatic load(logic [31:0] pc, int len, logic [7:0] salt);
    hdr(pc, len);
    words(pc, salt, 0, len);
  endtask

  task automatic lookup(logic [31:0] pc, logic exp_hit, string req);
    lk_valid = 1'b1; lk_pc = pc;
    step();
    lk_valid = 1'b0;
    check(req, {31'd0, fork_req}, {31'd0, exp_hit});
    check(req, {31'd0, out_valid}, {31'd0, exp_hit});
  endtask

  task automatic drain(logic [31:0] pc, logic [7:0] salt, int len, int inv_at, string req);
    out_ready = 1'b1;
    for (int i = 0; i < len; i++) begin
      check(req, {31'd0, out_valid}, 32'd1);
      check(req, out_insn, wfun(pc, salt, i));
      check(req, {31'd0, out_last}, {31'd0, (i == len - 1)});
      inv_all = (i == inv_at);
      step();
      inv_all = 1'b0;
    end
    check(req, {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {31'd0, fork_req}, 32'd0);
    check("R1", {24'd0, drop_cnt}, 32'd0);
    rst_n = 1'b1;
    step();
    lookup(32'h0000_1000, 1'b0, "R1");

    load(32'h0000_1000, 5,  8'h11);
    load(32'h0000_2000, 1,  8'h22);
    load(32'h0000_3000, 32, 8'h33);
    load(32'h0000_4000, 3,  8'h44);

    // Table walk: R2, R3, R11, R12
    for (int v = 0; v < 6; v++) begin
      lookup(VECS[v].pc, VECS[v].hit, "R2/R12 table");
      if (VECS[v].hit) drain(VECS[v].pc, VECS[v].salt, int'(VECS[v].len), -1, "R3/R11 table");
      step();
      check("R2", {31'd0, fork_req}, 32'd0);
    end

    // R12: lk_valid low
    lk_pc = 32'h0000_1000;
    step();
    check("R12", {31'd0, fork_req}, 32'd0);

    // R4: stall holds
    out_ready = 1'b0;
    lookup(32'h0000_1000, 1'b1, "R4");
    for (int s = 0; s < 3; s++) begin
      step();
      check("R4", {31'd0, out_valid}, 32'd1);
      check("R4", out_insn, wfun(32'h0000_1000, 8'h11, 0));
    end
    drain(32'h0000_1000, 8'h11, 5, -1, "R4");

    // R5: hit during stream is dropped
    out_ready = 1'b0;
    lookup(32'h0000_4000, 1'b1, "R5");
    lk_valid = 1'b1; lk_pc = 32'h0000_2000; out_ready = 1'b1;
    check("R5", out_insn, wfun(32'h0000_4000, 8'h44, 0));
    step();
    lk_valid = 1'b0;
    check("R5", {24'd0, drop_cnt}, 32'd1);
    check("R5", {31'd0, fork_req}, 32'd0);
    check("R5", out_insn, wfun(32'h0000_4000, 8'h44, 1));
    step();
    check("R5", out_insn, wfun(32'h0000_4000, 8'h44, 2));
    check("R5", {31'd0, out_last}, 32'd1);
    step();
    check("R5", {31'd0, out_valid}, 32'd0);

    // R6: saturation
    out_ready = 1'b0;
    lookup(32'h0000_3000, 1'b1, "R6");
    lk_valid = 1'b1; lk_pc = 32'h0000_2000;
    for (int k = 0; k < 300; k++) step();
    lk_valid = 1'b0;
    check("R6", {24'd0, drop_cnt}, 32'd255);
    drain(32'h0000_3000, 8'h33, 32, -1, "R6");
    check("R6", {24'd0, drop_cnt}, 32'd255);

    // R7: overwrite same trigger
    load(32'h0000_1000, 2, 8'h5A);
    lookup(32'h0000_1000, 1'b1, "R7");
    drain(32'h0000_1000, 8'h5A, 2, -1, "R7");

    // R9: partial entry invisible
    hdr(32'h0000_4800, 4);
    words(32'h0000_4800, 8'h48, 0, 2);
    lookup(32'h0000_4800, 1'b0, "R9");
    words(32'h0000_4800, 8'h48, 2, 2);
    lookup(32'h0000_4800, 1'b1, "R9");
    drain(32'h0000_4800, 8'h48, 4, -1, "R9");

    // R8: fill remaining slots, then round-robin from entry 0
    for (int k = 0; k < 11; k++) load(32'h0000_5000 + 32'(k * 16), 2, 8'(k));
    lookup(32'h0000_4000, 1'b1, "R8 no eviction");
    drain(32'h0000_4000, 8'h44, 3, -1, "R8");
    load(32'h0000_6000, 2, 8'h66);
    lookup(32'h0000_1000, 1'b0, "R8 victim0");
    lookup(32'h0000_6000, 1'b1, "R8");
    drain(32'h0000_6000, 8'h66, 2, -1, "R8");
    load(32'h0000_7000, 2, 8'h77);
    lookup(32'h0000_2000, 1'b0, "R8 victim1");
    lookup(32'h0000_5000, 1'b1, "R8");
    drain(32'h0000_5000, 8'h00, 2, -1, "R8");

    // R10: invalidate during stream, stream completes
    lookup(32'h0000_3000, 1'b1, "R10");
    drain(32'h0000_3000, 8'h33, 32, 2, "R10 stream continues");
    lookup(32'h0000_3000, 1'b0, "R10");
    lookup(32'h0000_7000, 1'b0, "R10");
    hdr(32'h0000_9000, 4);
    words(32'h0000_9000, 8'h99, 0, 1);
    inv_all = 1'b1;
    step();
    inv_all = 1'b0;
    words(32'h0000_9000, 8'h99, 1, 3);
    lookup(32'h0000_9000, 1'b0, "R10 fill abandoned");
    load(32'h0000_9000, 4, 8'h99);
    lookup(32'h0000_9000, 1'b1, "R10");
    drain(32'h0000_9000, 8'h99, 4, -1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule